// File: doc/BRIEF.md
# Threshold-Crossing Pulse Word Streamer

This block sits between a six-level threshold discriminator and a processor port. Whenever the capture logic finishes a pulse, it hands over one parallel record: how many threshold levels the pulse crossed, and for each level a rising-crossing time and a falling-crossing time. Each time is an integer count of the capture time step. Records wait in a small first-in first-out buffer until software drains them.

Software reads a pulse one word per pump strobe. The stream for a pulse is variable in length. It begins with the crossed-level count. Then, for each crossed level only, it gives that level's rising time and then its falling time, working upward from the lowest level. A zero word closes the stream. Two status outputs tell software when a record is waiting and when the capture side is stalled because every buffer slot is occupied. A run bit lets software pause acceptance of new records.

Top module: `pulse_word_streamer`

## Requirements
- R1: After reset, dataOut is 0, haveData is 0 and bufFull is 0.
- R2: The first word of each pulse stream is its crossed-level count, zero-extended. A count input of 7 is stored and sent as 6.
- R3: After the count, the stream holds exactly one pair per crossed level, ordered from level 0 upward. Each pair is the rising time and then the falling time. Level k occupies bits [k*TW +: TW] of recLead and of recTrail. Levels at or above the count are never sent.
- R4: After the last pair, one zero word is sent. The next pump then starts the following record with its count word.
- R5: One rising edge of ctrlBits[1] (the pump bit) delivers exactly one word. Holding the bit high delivers nothing more, and dataOut stays stable.
- R6: dataOut takes the new word on the first clock edge at which the pump bit is seen high after being low.
- R7: bufFull is high while DEPTH records are stored. A record offered while the buffer is full is discarded.
- R8: While ctrlBits[0] (the run bit) is 0, offered records are not stored.
- R9: haveData is high exactly while some stored record still has words left to send. A pump while haveData is 0 changes nothing.
- R10: Records stream out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlBits | input | 2 | Bit 0 is run (1 = accept records); bit 1 is the pump request |
| recValid | input | 1 | A capture record is presented this cycle |
| recCount | input | 3 | Number of levels crossed (0 to 6; 7 clamps to 6) |
| recLead | input | 6*TW | Rising-crossing times, level k at [k*TW +: TW] |
| recTrail | input | 6*TW | Falling-crossing times, level k at [k*TW +: TW] |
| dataOut | output | TW | Current stream word |
| haveData | output | 1 | A record still has words to send |
| bufFull | output | 1 | Every buffer slot is occupied; capture is stalled |

## Verification
The records use counts of 0, 3, 6 and the out-of-range 7. A zero count shows the count word followed straight by the terminator. The middle count shows that levels above the count are cut off. The full count and the clamped count show that every pair is sent and that the clamp works. Each record has different rising and falling values at every level, so a swap of the two halves or a level-order error shows up as a wrong word. Further patterns cover a pump held high for several cycles, pumps with the buffer empty, records offered while paused or while full, and several records queued back to back, which shows their order is kept.

// File: rtl/pstream_pkg.sv
`timescale 1ns/1ps
package pstream_pkg;
  localparam int LEVELS = 6;
  localparam int CNT_W  = 3;
  localparam int SEL_W  = $clog2(2 * LEVELS + 2);

  // Strobes from the sequencer into the record datapath
  typedef struct packed {
    logic             push;
    logic             pop;
    logic             emit;
    logic [SEL_W-1:0] sel;
  } seqStrobe_t;
endpackage

// File: rtl/pstream_datapath.sv
`timescale 1ns/1ps
module pstream_datapath
  import pstream_pkg::*;
#(
  parameter int TW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [CNT_W-1:0]      recCount,
  input  logic [LEVELS*TW-1:0]  recLead,
  input  logic [LEVELS*TW-1:0]  recTrail,
  output logic [CNT_W-1:0]      headCount,
  output logic                  occEmpty,
  output logic                  occFull,
  output logic [TW-1:0]         dataOut
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(LEVELS);

  logic [CNT_W-1:0]     cntMem   [DEPTH];
  logic [LEVELS*TW-1:0] leadMem  [DEPTH];
  logic [LEVELS*TW-1:0] trailMem [DEPTH];

  logic [AW-1:0] wrIdx, rdIdx;
  logic [OW-1:0] occ;
  logic [CNT_W-1:0] storeCnt;
  logic [TW-1:0] nextWord;

  assign storeCnt  = (recCount > MAX_CNT) ? MAX_CNT : recCount;
  assign occEmpty  = (occ == '0);
  assign occFull   = (occ == OW'(DEPTH));
  assign headCount = cntMem[rdIdx];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      cntMem[wrIdx]   <= storeCnt;
      leadMem[wrIdx]  <= recLead;
      trailMem[wrIdx] <= recTrail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      occ   <= '0;
    end else begin
      if (strobe.push)
        wrIdx <= (wrIdx == AW'(DEPTH - 1)) ? '0 : wrIdx + 1'b1;
      if (strobe.pop)
        rdIdx <= (rdIdx == AW'(DEPTH - 1)) ? '0 : rdIdx + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // Word selection: 0 = count, odd = rising time, even = falling time
  always_comb begin
    nextWord = '0;
    if (strobe.sel == '0)
      nextWord = TW'(headCount);
    for (int l = 0; l < LEVELS; l++) begin
      if (CNT_W'(l) < headCount) begin
        if (strobe.sel == SEL_W'(2 * l + 1))
          nextWord = leadMem[rdIdx][l*TW +: TW];
        if (strobe.sel == SEL_W'(2 * l + 2))
          nextWord = trailMem[rdIdx][l*TW +: TW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dataOut <= '0;
    else if (strobe.emit)
      dataOut <= nextWord;
  end

  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(DEPTH));
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (occ < OW'(DEPTH)));
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (occ != '0));
  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(dataOut));
  a_r4_term_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.pop) |=> (dataOut == '0));
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.sel == '0) |=> (dataOut <= TW'(LEVELS)));
endmodule

// File: rtl/pstream_sequencer.sv
`timescale 1ns/1ps
module pstream_sequencer
  import pstream_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             pump,
  input  logic             recValid,
  input  logic [CNT_W-1:0] headCount,
  input  logic             occEmpty,
  input  logic             occFull,
  output seqStrobe_t       strobe
);
  logic             pumpQ;
  logic             pumpRise;
  logic [SEL_W-1:0] wordIdx;
  logic [SEL_W-1:0] lastIdx;

  assign pumpRise = pump && !pumpQ;
  assign lastIdx  = SEL_W'({headCount, 1'b1});   // 2*count + 1

  always_comb begin
    strobe.emit = pumpRise && !occEmpty;
    strobe.sel  = wordIdx;
    strobe.pop  = strobe.emit && (wordIdx == lastIdx);
    strobe.push = recValid && runEn && !occFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pumpQ   <= 1'b0;
      wordIdx <= '0;
    end else begin
      pumpQ <= pump;
      if (strobe.emit)
        wordIdx <= strobe.pop ? '0 : wordIdx + 1'b1;
    end
  end

  a_r5_single_word: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> !strobe.emit);
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    !occEmpty |-> (wordIdx <= lastIdx));
  a_r9_idle_empty: assert property (@(posedge clk) disable iff (!rstN)
    occEmpty |-> (wordIdx == '0));
endmodule

// File: rtl/pulse_word_streamer.sv
`timescale 1ns/1ps
module pulse_word_streamer
  import pstream_pkg::*;
#(
  parameter int TW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           ctrlBits,
  input  logic                 recValid,
  input  logic [CNT_W-1:0]     recCount,
  input  logic [LEVELS*TW-1:0] recLead,
  input  logic [LEVELS*TW-1:0] recTrail,
  output logic [TW-1:0]        dataOut,
  output logic                 haveData,
  output logic                 bufFull
);
  seqStrobe_t       strobe;
  logic [CNT_W-1:0] headCount;
  logic             occEmpty;
  logic             occFull;

  pstream_sequencer u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (ctrlBits[0]),
    .pump      (ctrlBits[1]),
    .recValid  (recValid),
    .headCount (headCount),
    .occEmpty  (occEmpty),
    .occFull   (occFull),
    .strobe    (strobe)
  );

  pstream_datapath #(.TW(TW), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .recCount  (recCount),
    .recLead   (recLead),
    .recTrail  (recTrail),
    .headCount (headCount),
    .occEmpty  (occEmpty),
    .occFull   (occFull),
    .dataOut   (dataOut)
  );

  assign haveData = !occEmpty;
  assign bufFull  = occFull;
endmodule

// File: tb/pulse_word_streamer_tb.sv
`timescale 1ns/1ps
module pulse_word_streamer_tb;
  localparam int TW = 8;
  localparam int LV = 6;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ctrlBits = 2'b01;
  logic recValid = 1'b0;
  logic [2:0] recCount = '0;
  logic [LV*TW-1:0] recLead = '0;
  logic [LV*TW-1:0] recTrail = '0;
  logic [TW-1:0] dataOut;
  logic haveData, bufFull;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pulse_word_streamer #(.TW(TW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlBits(ctrlBits), .recValid(recValid),
    .recCount(recCount), .recLead(recLead), .recTrail(recTrail),
    .dataOut(dataOut), .haveData(haveData), .bufFull(bufFull)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [LV*TW-1:0] mkVec(input int base);
    logic [LV*TW-1:0] v;
    for (int l = 0; l < LV; l++) v[l*TW +: TW] = TW'(base + 3 * l + 1);
    return v;
  endfunction

  task automatic pushRec(input int c, input logic [LV*TW-1:0] ld, input logic [LV*TW-1:0] tr);
    @(negedge clk);
    recValid = 1'b1; recCount = 3'(c); recLead = ld; recTrail = tr;
    @(negedge clk);
    recValid = 1'b0;
  endtask

  task automatic pumpWord(output logic [TW-1:0] w);
    ctrlBits[1] = 1'b1;
    @(negedge clk);
    w = dataOut;
    ctrlBits[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic readPulse(input string tag, input int n,
                           input logic [LV*TW-1:0] ld, input logic [LV*TW-1:0] tr);
    logic [TW-1:0] w;
    pumpWord(w); check({tag, " R2 count word"}, w, n);
    for (int l = 0; l < n; l++) begin
      pumpWord(w); check({tag, " R3 rising time"}, w, ld[l*TW +: TW]);
      pumpWord(w); check({tag, " R3 falling time"}, w, tr[l*TW +: TW]);
    end
    pumpWord(w); check({tag, " R4 terminator"}, w, 0);
  endtask

  task automatic testReset();
    check("R1 dataOut", dataOut, 0);
    check("R1 haveData", haveData, 0);
    check("R1 bufFull", bufFull, 0);
  endtask

  task automatic testCounts();
    pushRec(3, mkVec(16), mkVec(96));
    check("R9 haveData after push", haveData, 1);
    readPulse("cnt3", 3, mkVec(16), mkVec(96));
    check("R9 haveData after drain", haveData, 0);
    pushRec(0, mkVec(40), mkVec(80));
    readPulse("cnt0", 0, mkVec(40), mkVec(80));
    pushRec(6, mkVec(50), mkVec(150));
    readPulse("cnt6", 6, mkVec(50), mkVec(150));
    pushRec(7, mkVec(60), mkVec(200));
    readPulse("cnt7 clamp R2", 6, mkVec(60), mkVec(200));
  endtask

  task automatic testHold();
    logic [TW-1:0] w;
    pushRec(2, mkVec(20), mkVec(120));
    ctrlBits[1] = 1'b1;
    @(negedge clk);
    check("R6 word on first edge", dataOut, 2);
    repeat (4) @(negedge clk);
    check("R5 held pump no advance", dataOut, 2);
    check("R9 haveData mid-stream", haveData, 1);
    ctrlBits[1] = 1'b0;
    @(negedge clk);
    pumpWord(w); check("R5 next word is level0 rising", w, 20 + 1);
    pumpWord(w); check("R5 level0 falling", w, 120 + 1);
    pumpWord(w); check("R3 level1 rising", w, 20 + 4);
    pumpWord(w); check("R3 level1 falling", w, 120 + 4);
    pumpWord(w); check("R4 terminator", w, 0);
  endtask

  task automatic testEmptyPump();
    logic [TW-1:0] w;
    pumpWord(w); check("R9 empty pump dataOut", w, 0);
    pumpWord(w); check("R9 empty pump haveData", haveData, 0);
    pushRec(1, mkVec(70), mkVec(170));
    readPulse("after empty pumps R9", 1, mkVec(70), mkVec(170));
  endtask

  task automatic testPause();
    ctrlBits[0] = 1'b0;
    pushRec(4, mkVec(30), mkVec(130));
    check("R8 paused not stored", haveData, 0);
    ctrlBits[0] = 1'b1;
    pushRec(1, mkVec(31), mkVec(131));
    readPulse("R8 after resume", 1, mkVec(31), mkVec(131));
    check("R8 paused record absent", haveData, 0);
  endtask

  task automatic testFullOrder();
    for (int i = 0; i < DEPTH; i++) pushRec(i + 1, mkVec(10 * i), mkVec(10 * i + 100));
    check("R7 bufFull at depth", bufFull, 1);
    pushRec(5, mkVec(90), mkVec(190));
    check("R7 still full after drop", bufFull, 1);
    for (int i = 0; i < DEPTH; i++) begin
      readPulse("R10 order", i + 1, mkVec(10 * i), mkVec(10 * i + 100));
      check("R7 bufFull clears", bufFull, 0);
    end
    check("R7 dropped record absent", haveData, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1'b1;
        @(negedge clk);
        testCounts();
        testHold();
        testEmptyPump();
        testPause();
        testFullOrder();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule